// File: doc/BRIEF.md
# Reset Entry Controller

This block sits next to a small processor core and takes it into the reset state. It has three sources of reset. The first is an active-low power-on pin. The second is an active-low manual pin. The third is a single-cycle reset command from the debug port.

While any source is active, the block pulses load strobes that initialise two core registers. The vector base register is loaded with zero. The status register is loaded with its mode, bank and block bits set and all interrupt mask bits set. The block also drives both status pins high for as long as the reset lasts. It records a cause code in an event register, and that register holds its value until the next reset.

When the reset ends, the fetch unit receives a one-cycle redirect to the fixed restart address. Both pins pass through two-flop synchronizers. The power-on pin asserts asynchronously and releases synchronously. A fixed priority selects which cause is recorded when sources overlap.

Top module: `rst_entry_ctrl`

## Requirements
- R1: While `por_n` is low, `vbr_ld` and `sr_ld` are high and `cause` reads 0x000, with no clock edge needed.
- R2: A low level on `man_n` is seen two clock edges after it is sampled. `vbr_ld`/`sr_ld` rise in that cycle, and `cause` becomes 0x020 one edge later.
- R3: A one-cycle `dbg_rst` pulse raises `vbr_ld`/`sr_ld` in the same cycle and records the cause 0x000.
- R4: Whenever `vbr_ld` is high, `vbr_value` is 0x00000000.
- R5: Whenever `sr_ld` is high, `sr_value` is 0x700000F0. In that value bit 30 is the mode bit, bit 29 is the bank bit and bit 28 is the block bit, bits 7:4 are the interrupt mask, and every other bit is 0.
- R6: `status_pins` is 2'b11 in every cycle that a reset is active and 2'b00 otherwise.
- R7: `redirect_vld` is high for exactly one cycle, in the first cycle after the reset goes inactive, with `redirect_addr` = 0xA0000000. It is never high while a reset is active.
- R8: When sources overlap, power-on wins over manual and manual wins over the debug command. For example, `dbg_rst` during a manual reset leaves `cause` at 0x020, and `por_n` low during a manual reset gives 0x000.
- R9: `cause` keeps the recorded code while no reset is active.
- R10: A `man_n` low pulse lasting one cycle still produces a one-cycle reset, two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| man_n | input | 1 | Manual reset pin, active low, asynchronous |
| dbg_rst | input | 1 | One-cycle reset command from the debug port, synchronous to clk |
| vbr_ld | output | 1 | Load strobe for the vector base register |
| vbr_value | output | 32 | Value to load into the vector base register |
| sr_ld | output | 1 | Load strobe for the status register |
| sr_value | output | 32 | Value to load into the status register |
| redirect_vld | output | 1 | One-cycle fetch redirect |
| redirect_addr | output | 32 | Restart address for the fetch unit |
| cause | output | 12 | Recorded reset cause code |
| status_pins | output | 2 | Status pins, both high during reset |

## Verification
The assertions assume that `dbg_rst` is driven synchronously to `clk`. They are all disabled while `por_n` is low, because the asynchronous clear makes the state jump outside any clock edge. The bench drives every input, including both pins, half a period away from the rising edge. It reads outputs one nanosecond later, so each sample shows the cycle's state before the next edge. The bench never releases `por_n` at the same moment as another source, which keeps the synchronizer latency it expects exact.

// File: rtl/rst_entry_ctrl.sv
module rst_entry_ctrl #(
  parameter int          AW        = 32,
  parameter int          SW        = 32,
  parameter int          CW        = 12,
  parameter logic [31:0] RESTART   = 32'hA000_0000,
  parameter logic [11:0] CAUSE_POR = 12'h000,
  parameter logic [11:0] CAUSE_MAN = 12'h020,
  parameter logic [11:0] CAUSE_DBG = 12'h000,
  parameter int          MD_BIT    = 30,
  parameter int          RB_BIT    = 29,
  parameter int          BL_BIT    = 28,
  parameter int          IM_LSB    = 4,
  parameter int          IM_W      = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          man_n,
  input  logic          dbg_rst,
  output logic          vbr_ld,
  output logic [AW-1:0] vbr_value,
  output logic          sr_ld,
  output logic [SW-1:0] sr_value,
  output logic          redirect_vld,
  output logic [AW-1:0] redirect_addr,
  output logic [CW-1:0] cause,
  output logic [1:0]    status_pins
);

  localparam logic [SW-1:0] ONE     = SW'(1);
  localparam logic [SW-1:0] IM_MASK = ((ONE << IM_W) - ONE) << IM_LSB;
  localparam logic [SW-1:0] SR_INIT = (ONE << MD_BIT) | (ONE << RB_BIT) |
                                      (ONE << BL_BIT) | IM_MASK;

  logic [1:0]    por_q, man_q;
  logic          hold_q;
  logic [CW-1:0] cause_q;
  logic          por_act, man_act, active;
  logic [CW-1:0] cause_nx;

  assign por_act = ~por_q[1];
  assign man_act = ~man_q[1];
  assign active  = por_act | man_act | dbg_rst;

  always_comb begin
    if (por_act)      cause_nx = CW'(CAUSE_POR);
    else if (man_act) cause_nx = CW'(CAUSE_MAN);
    else              cause_nx = CW'(CAUSE_DBG);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_q   <= 2'b00;
      man_q   <= 2'b11;
      hold_q  <= 1'b1;
      cause_q <= CW'(CAUSE_POR);
    end else begin
      por_q  <= {por_q[0], 1'b1};
      man_q  <= {man_q[0], man_n};
      hold_q <= active;
      if (active) cause_q <= cause_nx;
    end
  end

  assign vbr_ld        = active;
  assign sr_ld         = active;
  assign vbr_value     = '0;
  assign sr_value      = SR_INIT;
  assign status_pins   = {2{active}};
  assign redirect_vld  = hold_q & ~active;
  assign redirect_addr = AW'(RESTART);
  assign cause         = cause_q;

endmodule

// File: rtl/rst_entry_ctrl_chk.sv
module rst_entry_ctrl_chk #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          por_n,
  input logic          vbr_ld,
  input logic [AW-1:0] vbr_value,
  input logic          sr_ld,
  input logic          redirect_vld,
  input logic [CW-1:0] cause,
  input logic [1:0]    status_pins
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    redirect_vld |=> !redirect_vld);

  a_r7_after_hold: assert property (@(posedge clk) disable iff (!por_n)
    redirect_vld |-> $past(sr_ld));

  a_r7_not_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    sr_ld |-> !redirect_vld);

  a_r6_status_high: assert property (@(posedge clk) disable iff (!por_n)
    sr_ld |-> status_pins == 2'b11);

  a_r4_vbr_zero: assert property (@(posedge clk) disable iff (!por_n)
    vbr_ld |-> vbr_value == '0);

  a_r9_cause_held: assert property (@(posedge clk) disable iff (!por_n)
    (!sr_ld && !$past(sr_ld)) |-> $stable(cause));

endmodule

bind rst_entry_ctrl rst_entry_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .por_n(por_n), .vbr_ld(vbr_ld), .vbr_value(vbr_value),
  .sr_ld(sr_ld), .redirect_vld(redirect_vld), .cause(cause),
  .status_pins(status_pins)
);

// File: tb/rst_entry_ctrl_tb.sv
module rst_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        por_n, man_n, dbg_rst;
  logic        vbr_ld, sr_ld, redirect_vld;
  logic [31:0] vbr_value, sr_value, redirect_addr;
  logic [11:0] cause;
  logic [1:0]  status_pins;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_entry_ctrl u_dut (
    .clk(clk), .por_n(por_n), .man_n(man_n), .dbg_rst(dbg_rst),
    .vbr_ld(vbr_ld), .vbr_value(vbr_value), .sr_ld(sr_ld), .sr_value(sr_value),
    .redirect_vld(redirect_vld), .redirect_addr(redirect_addr),
    .cause(cause), .status_pins(status_pins)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_outputs(input string req, input logic on);
    chk(req, {31'd0, vbr_ld}, {31'd0, on});
    chk(req, {31'd0, sr_ld}, {31'd0, on});
    chk(req, {30'd0, status_pins}, on ? 32'd3 : 32'd0);
    if (on) begin
      chk({req, " R4 vbr"}, vbr_value, 32'h0);
      chk({req, " R5 sr"}, sr_value, 32'h7000_00F0);
    end
  endtask

  // {man_n, dbg_rst, exp_ld, exp_redirect, exp_cause[11:0]}
  localparam logic [15:0] VEC [21] = '{
    {4'b1000, 12'h000}, {4'b1110, 12'h000}, {4'b1001, 12'h000}, {4'b1000, 12'h000},
    {4'b0000, 12'h000}, {4'b0000, 12'h000}, {4'b0010, 12'h000}, {4'b0010, 12'h020},
    {4'b0110, 12'h020}, {4'b1010, 12'h020}, {4'b1010, 12'h020}, {4'b1001, 12'h020},
    {4'b1000, 12'h020}, {4'b1110, 12'h020}, {4'b1001, 12'h000}, {4'b1000, 12'h000},
    {4'b0000, 12'h000}, {4'b1000, 12'h000}, {4'b1010, 12'h000}, {4'b1001, 12'h020},
    {4'b1000, 12'h020}
  };

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; man_n = 1'b1; dbg_rst = 1'b0;
    #1;
    chk_reset_outputs("R1 por asserted", 1'b1);
    chk("R1 cause", {20'd0, cause}, 32'h000);
    chk("R7 no redirect in reset", {31'd0, redirect_vld}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) por_n = 1'b1;
    @(posedge clk); #1;
    chk_reset_outputs("R1 sync hold", 1'b1);
    @(posedge clk); #1;
    chk_reset_outputs("R7 released", 1'b0);
    chk("R7 redirect", {31'd0, redirect_vld}, 32'd1);
    chk("R7 addr", redirect_addr, 32'hA000_0000);
    @(posedge clk); #1;
    chk("R7 single pulse", {31'd0, redirect_vld}, 32'd0);

    // Table walk: manual, debug, priority, glitch, hold cases (R2 R3 R6 R7 R8 R9 R10)
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      man_n = VEC[i][15]; dbg_rst = VEC[i][14];
      #1;
      chk_reset_outputs($sformatf("R2/R3/R6/R10 row %0d", i), VEC[i][13]);
      chk($sformatf("R7 row %0d", i), {31'd0, redirect_vld}, {31'd0, VEC[i][12]});
      chk($sformatf("R8/R9 cause row %0d", i), {20'd0, cause}, {20'd0, VEC[i][11:0]});
    end
    @(negedge clk) dbg_rst = 1'b0;

    // R8: power-on overrides an active manual reset
    man_n = 1'b0;
    repeat (4) @(negedge clk);
    #1 chk("R8 manual recorded", {20'd0, cause}, 32'h020);
    @(negedge clk) por_n = 1'b0;
    #1 chk("R8 por wins", {20'd0, cause}, 32'h000);
    chk_reset_outputs("R1 por during manual", 1'b1);
    @(negedge clk) man_n = 1'b1;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (6) @(negedge clk);
    #1 chk("R9 cause after por", {20'd0, cause}, 32'h000);
    chk_reset_outputs("R6 idle", 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule